// File: doc/BRIEF.md
# Exponent Alignment Range Classifier

Before a floating-point add or subtract, the two operands must be brought to a common exponent. This block takes the 8-bit excess-128 exponents of a destination operand and a source operand and forms their difference, destination minus source, in a small exponent ALU. The ALU is made of chained 4-bit slices with ripple carry between them. The raw difference is then used as an index into a 256-entry, 4-bit-wide range table. The table entry, together with the borrow state of the subtraction, yields a range code. The sequencer uses that code to decide which fraction, if any, to right-shift, and whether the gap is so wide that the smaller operand vanishes entirely.

A start strobe captures one exponent pair. One clock later the block presents the difference, the range code and a shift amount, and pulses a valid flag. The shift amount is the magnitude of the signed difference, saturated at one more than the 56-bit double fraction width. The carry into the least significant slice must be exactly the one that subtraction needs. A spurious extra borrow would turn equal exponents into a difference of -1 and would misroute the alignment.

Top module: `exp_align_classifier`

## Requirements
- R1: `valid_o` is high in exactly the cycle after each cycle in which `start_i` was high at a rising clock edge, and low otherwise.
- R2: On valid, `diff_o` equals (dst − src) modulo 256. Equal exponents give 0 and never 255.
- R3: When the exponents are equal, `range_o` is 4'b1000 (bit 3 = equal) and `shift_o` is 0.
- R4: When the destination exponent is smaller, `range_o` bit 2 is set, bits 3 and 1 are clear, and `shift_o` = min(src − dst, 57).
- R5: When the source exponent is smaller, `range_o` bit 1 is set, bits 3 and 2 are clear, and `shift_o` = min(dst − src, 57).
- R6: `range_o` bit 0 is set exactly when |dst − src| > 56. In that case `shift_o` is 57; otherwise bit 0 is clear and `shift_o` ≤ 56.
- R7: In a cycle after which `start_i` was low at the edge, `diff_o`, `range_o` and `shift_o` keep their previous values.
- R8: While `rst_ni` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture the exponent pair this cycle |
| dst_exp_i | input | 8 | Destination biased exponent |
| src_exp_i | input | 8 | Source biased exponent |
| valid_o | output | 1 | Result valid pulse |
| diff_o | output | 8 | Raw difference dst − src mod 256 |
| range_o | output | 4 | [3] equal, [2] dst smaller, [1] src smaller, [0] beyond fraction width |
| shift_o | output | 6 | Right-shift amount for the smaller operand, saturated at 57 |

## Verification
The bench builds the block with its defaults: 8-bit exponents, 4-bit slices and a 56-bit fraction. At this size an exhaustive sweep of all 65,536 exponent pairs is cheap. The sweep reaches every table entry and every carry pattern across the slice boundary, including the equal case where a stray low carry would show up as 255. Start is withheld on a fixed pattern during the sweep, so the hold behaviour is checked against every prior result. Directed pairs at magnitudes 56 and 57 in both directions pin down the saturation edge.

// File: rtl/alc_pkg.sv
package alc_pkg;

  typedef struct packed {
    logic eq;
    logic dst_small;
    logic src_small;
    logic far;
  } range_code_t;

  // table entry: [3] zero index, [2] positive gap too wide,
  // [1] negative gap too wide, [0] positive gap within fraction width
  function automatic logic [3:0] rom_entry(input int idx, input int exp_w, input int frac_w);
    int neg_mag;
    logic [3:0] e;
    neg_mag = (1 << exp_w) - idx;
    e = '0;
    e[3] = (idx == 0);
    e[2] = (idx > frac_w);
    e[1] = (idx != 0) && (neg_mag > frac_w);
    e[0] = (idx != 0) && (idx <= frac_w);
    return e;
  endfunction

endpackage

// File: rtl/exp_slice.sv
module exp_slice #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] total;
  assign total  = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
  assign sum_o  = total[W-1:0];
  assign cout_o = total[W];
endmodule

// File: rtl/exp_alu.sv
module exp_alu #(
  parameter int EXP_W   = 8,
  parameter int SLICE_W = 4
) (
  input  logic [EXP_W-1:0] a_i,
  input  logic [EXP_W-1:0] b_i,
  input  logic             sub_i,
  output logic [EXP_W-1:0] diff_o,
  output logic             cout_o
);
  localparam int NUM_SLICES = EXP_W / SLICE_W;

  logic [EXP_W-1:0]    b_eff;
  logic [NUM_SLICES:0] carry;

  assign b_eff    = sub_i ? ~b_i : b_i;
  assign carry[0] = sub_i; // only the subtract's +1, nothing more

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    exp_slice #(.W(SLICE_W)) i_slice (
      .a_i   (a_i  [s*SLICE_W +: SLICE_W]),
      .b_i   (b_eff[s*SLICE_W +: SLICE_W]),
      .cin_i (carry[s]),
      .sum_o (diff_o[s*SLICE_W +: SLICE_W]),
      .cout_o(carry[s+1])
    );
  end

  assign cout_o = carry[NUM_SLICES];

  always_comb begin
    if (sub_i && (a_i == b_i)) begin
      p_equal_zero_r2 : assert (diff_o == '0 && cout_o);
    end
    if (sub_i) begin
      p_mod_diff_r2 : assert (diff_o == EXP_W'(a_i - b_i));
    end
  end
endmodule

// File: rtl/range_rom.sv
module range_rom #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 56
) (
  input  logic [EXP_W-1:0] idx_i,
  output logic [3:0]       entry_o
);
  localparam int DEPTH = 1 << EXP_W;

  logic [3:0] tbl [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assign tbl[i] = alc_pkg::rom_entry(i, EXP_W, FRAC_W);
  end

  assign entry_o = tbl[idx_i];

  always_comb begin
    p_excl_r6 : assert (!(entry_o[2] && entry_o[0]));
  end
endmodule

// File: rtl/exp_align_classifier.sv
module exp_align_classifier #(
  parameter int EXP_W   = 8,
  parameter int SLICE_W = 4,
  parameter int FRAC_W  = 56
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           start_i,
  input  logic [EXP_W-1:0]               dst_exp_i,
  input  logic [EXP_W-1:0]               src_exp_i,
  output logic                           valid_o,
  output logic [EXP_W-1:0]               diff_o,
  output logic [3:0]                     range_o,
  output logic [$clog2(FRAC_W+2)-1:0]    shift_o
);
  localparam int SAT  = FRAC_W + 1;
  localparam int SH_W = $clog2(FRAC_W + 2);

  logic [EXP_W-1:0]   diff;
  logic               no_borrow;
  logic [3:0]         ent;
  logic [EXP_W-1:0]   mag;
  alc_pkg::range_code_t code;
  logic [SH_W-1:0]    shift_d;

  exp_alu #(.EXP_W(EXP_W), .SLICE_W(SLICE_W)) i_alu (
    .a_i   (dst_exp_i),
    .b_i   (src_exp_i),
    .sub_i (1'b1),
    .diff_o(diff),
    .cout_o(no_borrow)
  );

  range_rom #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_rom (
    .idx_i  (diff),
    .entry_o(ent)
  );

  always_comb begin
    code.eq        = ent[3];
    code.dst_small = ~no_borrow;
    code.src_small = no_borrow & (ent[2] | ent[0]);
    code.far       = no_borrow ? ent[2] : ent[1];
    mag            = no_borrow ? diff : (~diff + 1'b1);
    shift_d        = code.far ? SH_W'(SAT) : SH_W'(mag);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      diff_o  <= '0;
      range_o <= '0;
      shift_o <= '0;
    end else begin
      valid_o <= start_i;
      if (start_i) begin
        diff_o  <= diff;
        range_o <= code;
        shift_o <= shift_d;
      end
    end
  end

  p_pulse_r1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o);
  p_equal_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && (dst_exp_i == src_exp_i) |=> range_o == 4'b1000 && shift_o == '0);
  p_dir_onehot_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $onehot(range_o[3:1]));
  p_dst_small_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && (dst_exp_i < src_exp_i) |=> range_o[2]);
  p_src_small_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && (dst_exp_i > src_exp_i) |=> range_o[1]);
  p_far_sat_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (range_o[0] == (shift_o == SH_W'(SAT))));
  p_hold_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !valid_o && $stable(range_o) && $stable(shift_o) && $stable(diff_o));
endmodule

// File: tb/test_exp_align_classifier.sv
module test_exp_align_classifier;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [7:0] dst, src;
  logic       valid;
  logic [7:0] diff;
  logic [3:0] range;
  logic [5:0] shift;

  int vectors = 0;
  int fails   = 0;

  // reference model state
  logic       m_valid;
  logic [7:0] m_diff;
  logic [3:0] m_range;
  logic [5:0] m_shift;
  string      m_tag;

  always #5 clk = ~clk;

  exp_align_classifier i_exp_align_classifier (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .start_i  (start),
    .dst_exp_i(dst),
    .src_exp_i(src),
    .valid_o  (valid),
    .diff_o   (diff),
    .range_o  (range),
    .shift_o  (shift)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0; m_diff <= '0; m_range <= '0; m_shift <= '0; m_tag <= "R8";
    end else begin
      m_valid <= start;
      if (!start) m_tag <= "R7";
      else begin
        int d;
        int m;
        d = int'(dst) - int'(src);
        m = (d < 0) ? -d : d;
        m_diff  <= 8'(d);
        m_shift <= 6'((m > 56) ? 57 : m);
        m_range <= {d == 0, d < 0, d > 0, m > 56};
        if (m > 56)      m_tag <= "R6";
        else if (d == 0) m_tag <= "R3";
        else if (d < 0)  m_tag <= "R4";
        else             m_tag <= "R5";
      end
    end
  end

  task automatic compare();
    vectors++;
    if (valid !== m_valid) begin
      fails++;
      $display("FAIL R1 valid act=%0b exp=%0b", valid, m_valid);
    end else if (diff !== m_diff) begin
      fails++;
      $display("FAIL R2 (%s) diff act=%0d exp=%0d", m_tag, diff, m_diff);
    end else if (range !== m_range || shift !== m_shift) begin
      fails++;
      $display("FAIL %s range/shift act=%b/%0d exp=%b/%0d", m_tag, range, shift, m_range, m_shift);
    end
  endtask

  task automatic step(input logic s, input int d, input int sr);
    @(negedge clk);
    compare();
    start = s; dst = 8'(d); src = 8'(sr);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start = 1'b1; dst = 8'd200; src = 8'd3;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: outputs stay zero in reset despite start
    vectors++;
    if (valid !== 1'b0 || diff !== '0 || range !== '0 || shift !== '0) begin
      fails++;
      $display("FAIL R8 reset act=%0b/%0d/%b/%0d exp=0/0/0000/0", valid, diff, range, shift);
    end
    start = 1'b0;
    rst_n = 1'b1;
    // R3 equal (0.5 + 0.5), R4/R5 small gaps, R6 edges at 56/57, R7 gaps
    step(1, 128, 128);
    step(0, 7, 9);
    step(1, 129, 128);
    step(1, 128, 129);
    step(1, 0, 56);
    step(1, 0, 57);
    step(1, 56, 0);
    step(1, 57, 0);
    step(0, 1, 200);
    step(0, 200, 1);
    step(1, 255, 0);
    step(1, 0, 255);
    step(1, 15, 16);  // borrow crosses slice boundary
    step(1, 16, 15);
    step(1, 240, 240);
    // exhaustive sweep: R2 all differences, R7 on withheld starts
    for (int d = 0; d < 256; d++) begin
      for (int s = 0; s < 256; s++) begin
        step(((d + s) % 5) != 0, d, s);
      end
    end
    step(0, 0, 0);
    step(0, 0, 0);
    finish_run();
  end
endmodule